// File: doc/BRIEF.md
# Flow-Controlled Pixel Output Stage

This block takes 24-bit pixels from a show-ahead pixel FIFO and sends them to a downstream display interface. Each pixel goes out with a one-cycle pixel-clock enable pulse, which marks the pixel clock's active edge. The downstream side throttles the stream with a stall input, but only while the stall-mode configuration bit is set. When stall mode is off, the stall input has no effect and a pixel goes out on every cycle.

A second configuration bit turns on a FIFO readiness check, and that bit has effect only while stall mode is also on. With the check on, the block issues no pixel pulse while stall is low unless the FIFO fill level has reached the `THRESH` parameter, or the FIFO holds the final pixels of a frame. The check therefore prevents underflow. A sticky underflow flag records any pulse that was issued while the FIFO was empty, which can happen only when the check is off.

A control state machine makes the decision each cycle. It has four states:
- `ST_IDLE` is entered on reset and left on the first clock edge.
- `ST_SEND` is the state in which a pixel is emitted.
- `ST_HOLD` is the state in which the stall holds output.
- `ST_STARVE` is the state in which the check holds output.

The transitions are:
- *start* runs from IDLE to any other state.
- *stall* runs from any state to HOLD.
- *release* runs from HOLD to SEND or STARVE.
- *starve* runs from any state to STARVE.
- *refill* runs from STARVE to SEND.
- *stream* is the SEND to SEND self-loop.

The next state is always chosen by one priority: stall first, then the check, then send.

Top module: `pix_stall_out`

## Requirements
- R1: While reset is asserted and right after it, `pclk_en`, `fifo_rd_en` and `underflow` are 0 and `pix_data` is 0.
- R2: With stall mode on and `stall_in` held high, no pixel pulse and no FIFO read occur, and `pix_data` keeps its last value even if the FIFO word changes.
- R3: After `stall_in` rises with stall mode on, at most `STALL_STAGES` further pulses are issued; this parameter is limited to 1..4 and defaults to 2, so exactly 2 pulses follow the rise under a full FIFO.
- R4: When stall mode is on, the clock edge that first samples `stall_in` low issues no pulse. The next edge issues one if the FIFO allows it.
- R5: With stall mode off, both `stall_in` and `cfg_fifo_chk` are ignored and a pulse is issued every cycle.
- R6: With stall mode and the check both on and stall low, a pulse is issued only when `fifo_level >= THRESH` (default 8), or when `fifo_last` is 1 and `fifo_level` is not 0.
- R7: `fifo_rd_en` is high in exactly the cycles whose closing clock edge raises `pclk_en`, and that edge loads the word read into `pix_data`.
- R8: The pixel word has blue in bits 7:0, green in bits 15:8 and red in bits 23:16 on both the FIFO side and the output side.
- R9: `underflow` sets on an edge that issues a pulse while `fifo_level` is 0, and stays set until reset. It never sets while the check and stall mode are both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_stall_mode | input | 1 | Enables stall flow control |
| cfg_fifo_chk | input | 1 | Enables FIFO readiness check (only with stall mode) |
| stall_in | input | 1 | Stall request from downstream |
| fifo_level | input | LVL_W | FIFO fill level in pixels |
| fifo_last | input | 1 | FIFO holds the final pixels of the frame |
| fifo_rd_data | input | 24 | Show-ahead FIFO head word |
| fifo_rd_en | output | 1 | FIFO pop strobe |
| pclk_en | output | 1 | Pixel-clock enable pulse |
| pix_data | output | 24 | Pixel output bus |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The hardest behaviour to reach from the ports is the boundary of the stall pipeline. The bench must count the pulses that escape after a stall rise, and it must find the exact edge on which output resumes after a release. To get there, the bench first streams a full FIFO at a steady rate, then toggles `stall_in` on a falling edge and counts `pclk_en` at every later falling edge. A second hard case is the frame tail, where the fill level is below the threshold but not zero. The bench drives `fifo_last` with levels just under the threshold and at zero, and compares the outcomes.

// File: rtl/pso_pkg.sv
`timescale 1ns/1ps
package pso_pkg;

    localparam int PIX_W = 24;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEND   = 2'd1,
        ST_HOLD   = 2'd2,
        ST_STARVE = 2'd3
    } pso_state_e;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } pso_pix_t;

endpackage

// File: rtl/pso_stall_sync.sv
`timescale 1ns/1ps
module pso_stall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_in,
    output logic stall_eff
);

    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= stall_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= '0;
                else        shreg <= {shreg[STAGES-2:0], stall_in};
            end
        end
    endgenerate

    // Asserts only when every stage holds stall; drops as soon as the newest stage drops.
    assign stall_eff = &shreg;

    // R4
    release_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_in |=> !stall_eff);

endmodule

// File: rtl/pso_fifo_gate.sv
`timescale 1ns/1ps
module pso_fifo_gate #(
    parameter int LVL_W  = 6,
    parameter int THRESH = 8
) (
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             fifo_last,
    output logic             has_data,
    output logic             ready
);

    localparam logic [LVL_W-1:0] THR_L = LVL_W'(THRESH);

    always_comb begin
        has_data = (fifo_level != '0);
        ready    = (fifo_level >= THR_L) || (fifo_last && has_data);
    end

    // R6
    ready_nonempty_chk: assert final (!ready || has_data || (THRESH == 0));

endmodule

// File: rtl/pso_ctrl_fsm.sv
`timescale 1ns/1ps
module pso_ctrl_fsm
    import pso_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall_mode,
    input  logic       chk_mode,
    input  logic       stall_eff,
    input  logic       ready,
    output pso_state_e state_q,
    output logic       emit
);

    pso_state_e state_d;
    logic       stall_act;
    logic       chk_act;

    assign stall_act = stall_mode && stall_eff;
    assign chk_act   = stall_mode && chk_mode;

    // Next-state process
    always_comb begin
        state_d = ST_SEND;
        unique case (state_q)
            ST_IDLE: begin
                if (stall_act)               state_d = ST_HOLD;
                else if (chk_act && !ready)  state_d = ST_STARVE;
                else                         state_d = ST_SEND;
            end
            ST_SEND: begin
                if (stall_act)               state_d = ST_HOLD;
                else if (chk_act && !ready)  state_d = ST_STARVE;
                else                         state_d = ST_SEND;
            end
            ST_HOLD: begin
                if (stall_act)               state_d = ST_HOLD;
                else if (chk_act && !ready)  state_d = ST_STARVE;
                else                         state_d = ST_SEND;
            end
            ST_STARVE: begin
                if (stall_act)               state_d = ST_HOLD;
                else if (chk_act && !ready)  state_d = ST_STARVE;
                else                         state_d = ST_SEND;
            end
            default:                         state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: emission is blocked in the first cycle out of reset
    always_comb begin
        emit = 1'b0;
        unique case (state_q)
            ST_IDLE:   emit = 1'b0;
            ST_SEND,
            ST_HOLD,
            ST_STARVE: emit = (state_d == ST_SEND);
            default:   emit = 1'b0;
        endcase
    end

    // R2
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_mode && stall_eff) |-> !emit);

    // R6
    starve_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_mode && chk_mode && !ready) |-> !emit);

    // R5
    free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_mode && state_q != ST_IDLE) |-> emit);

endmodule

// File: rtl/pso_out_reg.sv
`timescale 1ns/1ps
module pso_out_reg
    import pso_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit,
    input  logic              has_data,
    input  logic [PIX_W-1:0]  rd_data,
    output logic              pclk_en,
    output logic [PIX_W-1:0]  pix_data,
    output logic              underflow
);

    pso_pix_t pix_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pclk_en   <= 1'b0;
            pix_q     <= '0;
            underflow <= 1'b0;
        end else begin
            pclk_en <= emit;
            if (emit)              pix_q     <= pso_pix_t'(rd_data);
            if (emit && !has_data) underflow <= 1'b1;
        end
    end

    assign pix_data = {pix_q.red, pix_q.green, pix_q.blue};

    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !emit |=> $stable(pix_data));

endmodule

// File: rtl/pix_stall_out.sv
`timescale 1ns/1ps
module pix_stall_out
    import pso_pkg::*;
#(
    parameter int LVL_W        = 6,
    parameter int THRESH       = 8,
    parameter int STALL_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_stall_mode,
    input  logic             cfg_fifo_chk,
    input  logic             stall_in,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             fifo_last,
    input  logic [23:0]      fifo_rd_data,
    output logic             fifo_rd_en,
    output logic             pclk_en,
    output logic [23:0]      pix_data,
    output logic             underflow
);

    localparam int SS = (STALL_STAGES < 1) ? 1 : ((STALL_STAGES > 4) ? 4 : STALL_STAGES);

    logic       stall_eff;
    logic       has_data;
    logic       ready;
    logic       emit;
    pso_state_e state_q;

    pso_stall_sync #(.STAGES(SS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall_in  (stall_in),
        .stall_eff (stall_eff)
    );

    pso_fifo_gate #(.LVL_W(LVL_W), .THRESH(THRESH)) u_gate (
        .fifo_level (fifo_level),
        .fifo_last  (fifo_last),
        .has_data   (has_data),
        .ready      (ready)
    );

    pso_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_mode (cfg_stall_mode),
        .chk_mode   (cfg_fifo_chk),
        .stall_eff  (stall_eff),
        .ready      (ready),
        .state_q    (state_q),
        .emit       (emit)
    );

    pso_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (emit),
        .has_data  (has_data),
        .rd_data   (fifo_rd_data),
        .pclk_en   (pclk_en),
        .pix_data  (pix_data),
        .underflow (underflow)
    );

    assign fifo_rd_en = emit;

    // Checker state: consecutive cycles with stall requested under stall mode
    logic [2:0] stall_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                stall_run <= '0;
        else if (!(cfg_stall_mode && stall_in))    stall_run <= '0;
        else if (stall_run != 3'd7)                stall_run <= stall_run + 3'd1;
    end

    // R3
    stall_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stall_mode && stall_in && stall_run >= 3'(SS)) |-> !fifo_rd_en);

    // R7
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |=> pclk_en);

    // R7
    no_read_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_rd_en |=> !pclk_en);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stall_mode && cfg_fifo_chk && fifo_rd_en) |-> (fifo_level != '0));

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !fifo_rd_en);

endmodule

// File: tb/tb_pix_stall_out.sv
`timescale 1ns/1ps
module tb_pix_stall_out;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_stall_mode, cfg_fifo_chk, stall_in, fifo_last;
    logic [5:0]  fifo_level;
    logic [23:0] fifo_rd_data;
    logic        fifo_rd_en, pclk_en, underflow;
    logic [23:0] pix_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pix_stall_out dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_stall_mode(cfg_stall_mode), .cfg_fifo_chk(cfg_fifo_chk),
        .stall_in(stall_in), .fifo_level(fifo_level), .fifo_last(fifo_last),
        .fifo_rd_data(fifo_rd_data), .fifo_rd_en(fifo_rd_en),
        .pclk_en(pclk_en), .pix_data(pix_data), .underflow(underflow)
    );

    typedef struct packed {
        logic        sm;
        logic        ck;
        logic        st;
        logic [5:0]  lv;
        logic        ls;
        logic [23:0] dat;
        logic        exp_en;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b0, 6'd10, 1'b0, 24'h112233, 1'b1, 4'd5}, // R5 plain stream
        '{1'b0, 1'b0, 1'b1, 6'd10, 1'b0, 24'h445566, 1'b1, 4'd5}, // R5 stall ignored
        '{1'b1, 1'b0, 1'b1, 6'd10, 1'b0, 24'h778899, 1'b0, 4'd2}, // R2 stall holds
        '{1'b1, 1'b0, 1'b0, 6'd10, 1'b0, 24'hA1B2C3, 1'b1, 4'd4}, // R4 resumed
        '{1'b1, 1'b1, 1'b0, 6'd7,  1'b0, 24'h0F0F0F, 1'b0, 4'd6}, // R6 below threshold
        '{1'b1, 1'b1, 1'b0, 6'd8,  1'b0, 24'h808080, 1'b1, 4'd6}, // R6 at threshold
        '{1'b1, 1'b1, 1'b0, 6'd3,  1'b1, 24'h030303, 1'b1, 4'd6}, // R6 frame tail
        '{1'b1, 1'b1, 1'b0, 6'd0,  1'b1, 24'hDEAD00, 1'b0, 4'd6}, // R6 tail but empty
        '{1'b0, 1'b1, 1'b0, 6'd3,  1'b0, 24'h5A5A5A, 1'b1, 4'd5}, // R5 check ignored
        '{1'b1, 1'b1, 1'b1, 6'd20, 1'b0, 24'h777777, 1'b0, 4'd2}, // R2 stall with check
        '{1'b1, 1'b0, 1'b0, 6'd2,  1'b0, 24'h246813, 1'b1, 4'd7}  // R7 low level, no check
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic drive(input logic sm, ck, st, input logic [5:0] lv, input logic ls,
                         input logic [23:0] d);
        cfg_stall_mode = sm; cfg_fifo_chk = ck; stall_in = st;
        fifo_level = lv; fifo_last = ls; fifo_rd_data = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [23:0] held;
        int cnt;
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 6'd0, 1'b0, 24'h0);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pclk_en", 32'(pclk_en), 0);
        chk("R1 pix_data", 32'(pix_data), 0);
        chk("R1 underflow", 32'(underflow), 0);
        chk("R1 rd_en", 32'(fifo_rd_en), 0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].sm, VEC[i].ck, VEC[i].st, VEC[i].lv, VEC[i].ls, VEC[i].dat);
            repeat (4) @(negedge clk);
            chk($sformatf("R%0d vec%0d pclk_en", VEC[i].req, i), 32'(pclk_en), 32'(VEC[i].exp_en));
            chk($sformatf("R%0d vec%0d rd_en", VEC[i].req, i), 32'(fifo_rd_en), 32'(VEC[i].exp_en));
            if (VEC[i].exp_en)
                chk($sformatf("R7 vec%0d pix_data", i), 32'(pix_data), 32'(VEC[i].dat));
        end
        chk("R9 no underflow in table", 32'(underflow), 0);

        // R8 colour layout
        drive(1'b1, 1'b0, 1'b0, 6'd20, 1'b0, {8'hC1, 8'h62, 8'h0B});
        repeat (2) @(negedge clk);
        chk("R8 blue", 32'(pix_data[7:0]), 32'h0B);
        chk("R8 green", 32'(pix_data[15:8]), 32'h62);
        chk("R8 red", 32'(pix_data[23:16]), 32'hC1);

        // R3 pulses after stall rise
        stall_in = 1'b1;
        cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (pclk_en) cnt++;
        end
        chk("R3 pulses after stall", 32'(cnt), 2);

        // R2 data held while stalled
        held = pix_data;
        fifo_rd_data = 24'h99AA55;
        repeat (3) @(negedge clk);
        chk("R2 pix_data held", 32'(pix_data), 32'(held));
        chk("R2 no pulse", 32'(pclk_en), 0);

        // R4 restart edge
        stall_in = 1'b0;
        @(negedge clk);
        chk("R4 no pulse on release edge", 32'(pclk_en), 0);
        @(negedge clk);
        chk("R4 pulse next edge", 32'(pclk_en), 1);
        chk("R4 new data", 32'(pix_data), 32'h99AA55);

        // R9 underflow with check on and an empty FIFO: must stay clear
        drive(1'b1, 1'b1, 1'b0, 6'd0, 1'b0, 24'h1);
        repeat (3) @(negedge clk);
        chk("R9 check prevents underflow", 32'(underflow), 0);

        // R9 underflow when stall mode off and FIFO empty
        drive(1'b0, 1'b1, 1'b0, 6'd0, 1'b0, 24'h2);
        @(negedge clk);
        chk("R9 underflow sets", 32'(underflow), 1);
        fifo_level = 6'd30;
        repeat (3) @(negedge clk);
        chk("R9 underflow sticky", 32'(underflow), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears underflow", 32'(underflow), 0);
        chk("R1 reset clears pix_data", 32'(pix_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 first cycle no read", 32'(pclk_en), 0);

        finish_run();
    end

endmodule